// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation buffer for a memory management unit. Each slot keeps a virtual page number, a physical page number and an address space number. It also keeps a global flag, per-privilege-mode read and write enable masks, and two trap bits: one that makes reads fault and one that makes writes fault. A lookup presents a virtual page number and the current address space number. It returns, combinationally, whether some slot matches, together with that slot's physical page and attributes.

The block has no page-table walker. When a miss occurs, software or a walker elsewhere installs the translation with an insert command. The insert always lands in the slot named by a rotating replacement pointer.

Three invalidation commands are provided:
- wiping the whole buffer;
- wiping only the entries private to a process, so that global ones stay;
- wiping the entries that a given page and address space number would hit.

A short list of recently hit slot indices is searched ahead of the full match vector. This list is emptied by every insert and by every flush.

Top module: `tlb_asn_top`

## Requirements
- R1: A lookup hits a slot only when the slot is valid, its stored page number equals `lk_vpn`, and either its global flag is set or its stored address space number equals `lk_asn`.
- R2: On a miss, `lk_ppn`, `lk_global`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd` and `lk_fault_wr` are all zero. On a hit with a single matching slot, they carry that slot's stored fields.
- R3: `cmd`=1 (insert) writes every field of the slot under the replacement pointer and marks it valid, on the clock edge. A lookup made in the same cycle as the insert sees the contents from before the insert, and a lookup in the next cycle sees the new entry.
- R4: The replacement pointer advances by one after each insert and wraps from ENTRIES-1 to 0. The insert that follows ENTRIES inserts replaces the oldest entry, which then no longer hits.
- R5: `cmd`=2 clears every slot and returns the replacement pointer to slot 0.
- R6: `cmd`=3 invalidates every slot whose global flag is clear and leaves global slots valid and unchanged.
- R7: `cmd`=4 invalidates every slot that a lookup of (`cmd_vpn`, `cmd_asn`) would hit under the R1 rule, and leaves all other slots untouched.
- R8: `cmd` values 0, 5, 6 and 7 change no slot and do not move the replacement pointer.
- R9: After reset every slot is invalid, so every lookup misses, and the replacement pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup is real; a hit updates the recent-hit list |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address space number |
| lk_hit | output | 1 | Some slot matches |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_global | output | 1 | Global flag of the matching slot |
| lk_rd_en | output | MODES | Per-mode read enables of the matching slot |
| lk_wr_en | output | MODES | Per-mode write enables of the matching slot |
| lk_fault_rd | output | 1 | Read-trap bit of the matching slot |
| lk_fault_wr | output | 1 | Write-trap bit of the matching slot |
| cmd | input | 3 | 0 idle, 1 insert, 2 wipe all, 3 wipe non-global, 4 wipe page; 5 to 7 ignored |
| cmd_vpn | input | VPN_W | Page number for insert and wipe page |
| cmd_asn | input | ASN_W | Address space number for insert and wipe page |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | MODES | Read enables to insert |
| ins_wr_en | input | MODES | Write enables to insert |
| ins_fault_rd | input | 1 | Read-trap bit to insert |
| ins_fault_wr | input | 1 | Write-trap bit to insert |

## Verification
The bench builds the buffer with four slots, 4-bit page numbers and 2-bit address space numbers. With that configuration, every command is followed by a sweep of all 64 page and address-space combinations, which are compared against a model kept in the bench. Four slots let one run cover pointer wrap, eviction of the oldest entry, and each flush acting on a mix of global and private entries. The sweeps hold lookups valid across clock edges so that the recent-hit list fills and is then emptied by the following command.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE       = 3'd0,
        CMD_INSERT     = 3'd1,
        CMD_WIPE_ALL   = 3'd2,
        CMD_WIPE_LOCAL = 3'd3,
        CMD_WIPE_PAGE  = 3'd4
    } tlb_cmd_e;
endpackage

// File: rtl/tlb_asn_store.sv
module tlb_asn_store
    import tlb_asn_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 12,
    parameter int PPN_W   = 10,
    parameter int ASN_W   = 4,
    parameter int MODES   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASN_W-1:0]   lk_asn,
    input  logic [2:0]         cmd,
    input  logic [VPN_W-1:0]   cmd_vpn,
    input  logic [ASN_W-1:0]   cmd_asn,
    input  logic [IDX_W-1:0]   victim,
    input  logic [PPN_W-1:0]   ins_ppn,
    input  logic               ins_global,
    input  logic [MODES-1:0]   ins_rd_en,
    input  logic [MODES-1:0]   ins_wr_en,
    input  logic               ins_fault_rd,
    input  logic               ins_fault_wr,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [PPN_W-1:0]   sel_ppn,
    output logic               sel_global,
    output logic [MODES-1:0]   sel_rd_en,
    output logic [MODES-1:0]   sel_wr_en,
    output logic               sel_fault_rd,
    output logic               sel_fault_wr
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] glob_q;
    logic [ENTRIES-1:0] frd_q;
    logic [ENTRIES-1:0] fwr_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ASN_W-1:0]   asn_q [ENTRIES];
    logic [MODES-1:0]   rd_q  [ENTRIES];
    logic [MODES-1:0]   wr_q  [ENTRIES];
    logic [ENTRIES-1:0] page_vec;
    tlb_cmd_e           op;

    assign op = tlb_cmd_e'(cmd);

    // Per-slot comparators for the lookup port and for the wipe-page command
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e]  = valid_q[e] && (vpn_q[e] == lk_vpn) &&
                             (glob_q[e] || (asn_q[e] == lk_asn));
        assign page_vec[e] = valid_q[e] && (vpn_q[e] == cmd_vpn) &&
                             (glob_q[e] || (asn_q[e] == cmd_asn));
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                glob_q[e]  <= 1'b0;
                frd_q[e]   <= 1'b0;
                fwr_q[e]   <= 1'b0;
                vpn_q[e]   <= '0;
                ppn_q[e]   <= '0;
                asn_q[e]   <= '0;
                rd_q[e]    <= '0;
                wr_q[e]    <= '0;
            end else begin
                unique case (op)
                    CMD_INSERT: begin
                        if (victim == IDX_W'(e)) begin
                            valid_q[e] <= 1'b1;
                            glob_q[e]  <= ins_global;
                            frd_q[e]   <= ins_fault_rd;
                            fwr_q[e]   <= ins_fault_wr;
                            vpn_q[e]   <= cmd_vpn;
                            ppn_q[e]   <= ins_ppn;
                            asn_q[e]   <= cmd_asn;
                            rd_q[e]    <= ins_rd_en;
                            wr_q[e]    <= ins_wr_en;
                        end
                    end
                    CMD_WIPE_ALL: begin
                        valid_q[e] <= 1'b0;
                        glob_q[e]  <= 1'b0;
                        frd_q[e]   <= 1'b0;
                        fwr_q[e]   <= 1'b0;
                        vpn_q[e]   <= '0;
                        ppn_q[e]   <= '0;
                        asn_q[e]   <= '0;
                        rd_q[e]    <= '0;
                        wr_q[e]    <= '0;
                    end
                    CMD_WIPE_LOCAL: begin
                        if (!glob_q[e]) valid_q[e] <= 1'b0;
                    end
                    CMD_WIPE_PAGE: begin
                        if (page_vec[e]) valid_q[e] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sel_ppn      = ppn_q[sel_idx];
    assign sel_global   = glob_q[sel_idx];
    assign sel_rd_en    = rd_q[sel_idx];
    assign sel_wr_en    = wr_q[sel_idx];
    assign sel_fault_rd = frd_q[sel_idx];
    assign sel_fault_wr = fwr_q[sel_idx];
endmodule

// File: rtl/tlb_asn_victim.sv
module tlb_asn_victim
    import tlb_asn_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
    tlb_cmd_e op;

    assign op = tlb_cmd_e'(cmd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim <= '0;
        end else begin
            unique case (op)
                CMD_INSERT:   victim <= (victim == LAST) ? '0 : victim + 1'b1;
                CMD_WIPE_ALL: victim <= '0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlb_asn_recent.sv
module tlb_asn_recent #(
    parameter int ENTRIES = 8,
    parameter int RECENT  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic               clear,
    input  logic [ENTRIES-1:0] hit_vec,
    output logic               any_hit,
    output logic [IDX_W-1:0]   sel_idx
);
    logic [IDX_W-1:0]  slot_idx_q [RECENT];
    logic [RECENT-1:0] slot_v_q;
    logic [IDX_W-1:0]  scan_idx;
    logic              recent_found;
    logic [IDX_W-1:0]  recent_idx;

    // Full search: lowest matching slot index
    always_comb begin
        scan_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) scan_idx = IDX_W'(i);
        end
    end

    // Recent list search: earliest list position whose slot still matches
    always_comb begin
        recent_found = 1'b0;
        recent_idx   = '0;
        for (int s = RECENT - 1; s >= 0; s--) begin
            if (slot_v_q[s] && hit_vec[slot_idx_q[s]]) begin
                recent_found = 1'b1;
                recent_idx   = slot_idx_q[s];
            end
        end
    end

    assign any_hit = |hit_vec;
    assign sel_idx = recent_found ? recent_idx : scan_idx;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slot_v_q <= '0;
            for (int s = 0; s < RECENT; s++) slot_idx_q[s] <= '0;
        end else if (lk_valid && any_hit &&
                     !(slot_v_q[0] && slot_idx_q[0] == sel_idx)) begin
            slot_v_q[0]   <= 1'b1;
            slot_idx_q[0] <= sel_idx;
            for (int s = 1; s < RECENT; s++) begin
                slot_v_q[s]   <= slot_v_q[s-1];
                slot_idx_q[s] <= slot_idx_q[s-1];
            end
        end
    end
endmodule

// File: rtl/tlb_asn_top.sv
module tlb_asn_top
    import tlb_asn_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 12,
    parameter int PPN_W   = 10,
    parameter int ASN_W   = 4,
    parameter int MODES   = 4,
    parameter int RECENT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_global,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    input  logic [2:0]       cmd,
    input  logic [VPN_W-1:0] cmd_vpn,
    input  logic [ASN_W-1:0] cmd_asn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   sel_idx;
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic               list_clear;
    logic [PPN_W-1:0]   sel_ppn;
    logic               sel_global;
    logic [MODES-1:0]   sel_rd_en;
    logic [MODES-1:0]   sel_wr_en;
    logic               sel_fault_rd;
    logic               sel_fault_wr;

    always_comb begin
        unique case (tlb_cmd_e'(cmd))
            CMD_INSERT, CMD_WIPE_ALL, CMD_WIPE_LOCAL, CMD_WIPE_PAGE: list_clear = 1'b1;
            default: list_clear = 1'b0;
        endcase
    end

    tlb_asn_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .victim(victim)
    );

    tlb_asn_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .ASN_W(ASN_W), .MODES(MODES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .cmd(cmd), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .victim(victim),
        .ins_ppn(ins_ppn), .ins_global(ins_global), .ins_rd_en(ins_rd_en),
        .ins_wr_en(ins_wr_en), .ins_fault_rd(ins_fault_rd),
        .ins_fault_wr(ins_fault_wr), .sel_idx(sel_idx), .hit_vec(hit_vec),
        .sel_ppn(sel_ppn), .sel_global(sel_global), .sel_rd_en(sel_rd_en),
        .sel_wr_en(sel_wr_en), .sel_fault_rd(sel_fault_rd),
        .sel_fault_wr(sel_fault_wr)
    );

    tlb_asn_recent #(.ENTRIES(ENTRIES), .RECENT(RECENT)) u_recent (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .clear(list_clear),
        .hit_vec(hit_vec), .any_hit(any_hit), .sel_idx(sel_idx)
    );

    always_comb begin
        lk_hit      = any_hit;
        lk_ppn      = any_hit ? sel_ppn      : '0;
        lk_global   = any_hit ? sel_global   : 1'b0;
        lk_rd_en    = any_hit ? sel_rd_en    : '0;
        lk_wr_en    = any_hit ? sel_wr_en    : '0;
        lk_fault_rd = any_hit ? sel_fault_rd : 1'b0;
        lk_fault_wr = any_hit ? sel_fault_wr : 1'b0;
    end
endmodule

// File: rtl/tlb_asn_chk.sv
module tlb_asn_chk #(
    parameter int VPN_W = 12,
    parameter int PPN_W = 10,
    parameter int ASN_W = 4,
    parameter int MODES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd,
    input logic [VPN_W-1:0] cmd_vpn,
    input logic [ASN_W-1:0] cmd_asn,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [ASN_W-1:0] lk_asn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             lk_global,
    input logic [MODES-1:0] lk_rd_en,
    input logic [MODES-1:0] lk_wr_en,
    input logic             lk_fault_rd,
    input logic             lk_fault_wr
);
    // R2
    miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && !lk_global && lk_rd_en == '0 &&
                     lk_wr_en == '0 && !lk_fault_rd && !lk_fault_wr));

    // R3
    insert_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && lk_vpn == cmd_vpn && lk_asn == cmd_asn)
        |=> (!$stable(lk_vpn) || !$stable(lk_asn) || lk_hit));

    // R5
    wipe_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2) |=> !lk_hit);

    // R6
    wipe_local_global_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3) |=> (!lk_hit || lk_global));

    // R7
    wipe_page_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4 && lk_vpn == cmd_vpn && lk_asn == cmd_asn)
        |=> (!$stable(lk_vpn) || !$stable(lk_asn) || !lk_hit));
endmodule

bind tlb_asn_top tlb_asn_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .lk_global(lk_global), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr)
);

// File: tb/test_tlb_asn_top.sv
`timescale 1ns/1ps
module test_tlb_asn_top;
    localparam int E  = 4;
    localparam int VW = 4;
    localparam int PW = 6;
    localparam int AW = 2;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asn = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic          lk_global;
    logic [MW-1:0] lk_rd_en, lk_wr_en;
    logic          lk_fault_rd, lk_fault_wr;
    logic [2:0]    cmd = '0;
    logic [VW-1:0] cmd_vpn = '0;
    logic [AW-1:0] cmd_asn = '0;
    logic [PW-1:0] ins_ppn = '0;
    logic          ins_global = 1'b0;
    logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic          ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model of the slots
    bit            m_v   [E];
    logic [VW-1:0] m_vpn [E];
    logic [PW-1:0] m_ppn [E];
    logic [AW-1:0] m_asn [E];
    bit            m_g   [E];
    logic [MW-1:0] m_rd  [E];
    logic [MW-1:0] m_wr  [E];
    bit            m_fr  [E];
    bit            m_fw  [E];
    int            m_ptr;

    always #4 clk = ~clk;

    tlb_asn_top #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW),
                  .MODES(MW), .RECENT(2)) i_tlb_asn_top (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .lk_global(lk_global), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr), .cmd(cmd),
        .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .ins_ppn(ins_ppn),
        .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr)
    );

    function automatic bit m_match(int e, logic [VW-1:0] v, logic [AW-1:0] a);
        return m_v[e] && m_vpn[e] == v && (m_g[e] || m_asn[e] == a);
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Compare the combinational lookup result with the model
    task automatic check_lookup(string tag);
        int n = 0;
        int f = 0;
        logic [PW+2*MW+3-1:0] act, exp;
        for (int e = E - 1; e >= 0; e--) begin
            if (m_match(e, lk_vpn, lk_asn)) begin
                n++;
                f = e;
            end
        end
        act = {lk_ppn, lk_global, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr};
        if (n == 0) exp = '0;
        else exp = {m_ppn[f], m_g[f], m_rd[f], m_wr[f], m_fr[f], m_fw[f]};
        checks++;
        if (lk_hit !== (n > 0) || (n <= 1 && act !== exp)) begin
            errors++;
            $display("FAIL %s vpn=%0d asn=%0d: actual hit=%0b fields=%h expected hit=%0b fields=%h",
                     tag, lk_vpn, lk_asn, lk_hit, act, (n > 0), exp);
        end
    endtask

    // Sweep every page/asn pair, crossing a clock edge after each page
    task automatic sweep(string tag);
        lk_valid = 1'b1;
        for (int v = 0; v < (1 << VW); v++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                lk_vpn = VW'(v);
                lk_asn = AW'(a);
                #0.2;
                check_lookup(tag);
            end
            @(posedge clk); #1;
            check_lookup(tag);
        end
        lk_valid = 1'b0;
    endtask

    task automatic model_apply(logic [2:0] c);
        case (c)
            3'd1: begin
                m_v[m_ptr] = 1; m_vpn[m_ptr] = cmd_vpn; m_asn[m_ptr] = cmd_asn;
                m_ppn[m_ptr] = ins_ppn; m_g[m_ptr] = ins_global;
                m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
                m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
                m_ptr = (m_ptr + 1) % E;
            end
            3'd2: begin
                for (int e = 0; e < E; e++) begin
                    m_v[e] = 0; m_vpn[e] = '0; m_asn[e] = '0; m_ppn[e] = '0; m_g[e] = 0;
                    m_rd[e] = '0; m_wr[e] = '0; m_fr[e] = 0; m_fw[e] = 0;
                end
                m_ptr = 0;
            end
            3'd3: for (int e = 0; e < E; e++) if (!m_g[e]) m_v[e] = 0;
            3'd4: for (int e = 0; e < E; e++) if (m_match(e, cmd_vpn, cmd_asn)) m_v[e] = 0;
            default: ;
        endcase
    endtask

    task automatic issue(logic [2:0] c, int v, int a, int p, bit g);
        cmd = c; cmd_vpn = VW'(v); cmd_asn = AW'(a); ins_ppn = PW'(p);
        ins_global = g; ins_rd_en = MW'(p * 3); ins_wr_en = MW'(p * 5 + 1);
        ins_fault_rd = p[0]; ins_fault_wr = p[1];
        @(posedge clk); #1;
        model_apply(c);
        cmd = 3'd0;
    endtask

    task automatic probe(string tag, int v, int a, bit exp_hit);
        lk_vpn = VW'(v); lk_asn = AW'(a);
        #0.2;
        check_bit(tag, "probe hit", lk_hit, exp_hit);
        check_lookup(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < E; e++) begin
            m_v[e] = 0; m_vpn[e] = '0; m_asn[e] = '0; m_ppn[e] = '0; m_g[e] = 0;
            m_rd[e] = '0; m_wr[e] = '0; m_fr[e] = 0; m_fw[e] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset state, all lookups miss
        sweep("R9");

        // R3: lookup in the insert cycle sees old contents, next cycle sees new
        cmd = 3'd1; cmd_vpn = 4'd1; cmd_asn = 2'd1; ins_ppn = 6'd11;
        ins_global = 0; ins_rd_en = 4'b0011; ins_wr_en = 4'b0001;
        ins_fault_rd = 1; ins_fault_wr = 0;
        lk_vpn = 4'd1; lk_asn = 2'd1;
        #0.2;
        check_bit("R3", "same-cycle lookup", lk_hit, 1'b0);
        @(posedge clk); #1;
        model_apply(3'd1);
        cmd = 3'd0;
        probe("R3", 1, 1, 1'b1);

        // R1/R2: mix of global and private entries
        issue(3'd1, 2, 2, 22, 1);
        issue(3'd1, 3, 0, 33, 0);
        issue(3'd1, 1, 3, 45, 0);
        probe("R1", 2, 0, 1'b1);
        probe("R1", 3, 1, 1'b0);
        probe("R1", 1, 0, 1'b0);
        sweep("R1");
        sweep("R2");

        // R4: fifth insert wraps and evicts slot 0 (vpn 1, asn 1)
        issue(3'd1, 5, 1, 50, 0);
        probe("R4", 1, 1, 1'b0);
        probe("R4", 5, 1, 1'b1);
        issue(3'd1, 6, 2, 61, 1);
        probe("R4", 2, 2, 1'b0);
        sweep("R4");

        // R8: unused command codes and idle have no effect
        for (int c = 5; c < 8; c++) issue(3'(c), 3, 0, 7, 1);
        issue(3'd0, 3, 0, 7, 1);
        issue(3'd1, 7, 3, 17, 0);
        probe("R8", 7, 3, 1'b1);
        probe("R8", 3, 0, 1'b0);
        sweep("R8");

        // R7: wipe page by asn match and via global flag; mismatch keeps entry
        issue(3'd1, 9, 1, 39, 1);
        issue(3'd1, 10, 2, 40, 0);
        issue(3'd4, 10, 3, 0, 0);
        probe("R7", 10, 2, 1'b1);
        issue(3'd4, 10, 2, 0, 0);
        probe("R7", 10, 2, 1'b0);
        issue(3'd4, 9, 0, 0, 0);
        probe("R7", 9, 1, 1'b0);
        sweep("R7");

        // R6: wipe non-global entries keeps global ones
        issue(3'd1, 12, 0, 12, 1);
        issue(3'd1, 13, 1, 13, 0);
        issue(3'd1, 14, 2, 14, 1);
        issue(3'd1, 15, 3, 15, 0);
        sweep("R6");
        issue(3'd3, 0, 0, 0, 0);
        probe("R6", 12, 3, 1'b1);
        probe("R6", 13, 1, 1'b0);
        sweep("R6");

        // R5: wipe all, then pointer restarts at slot 0
        issue(3'd2, 0, 0, 0, 0);
        sweep("R5");
        for (int k = 0; k < E; k++) issue(3'd1, k + 1, 0, k + 20, 0);
        issue(3'd1, 8, 0, 30, 0);
        probe("R5", 1, 0, 1'b0);
        probe("R5", 2, 0, 1'b1);
        sweep("R5");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule